// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This combinational unit moves an operand by exactly one bit position and reports the condition flags of the outcome. It handles byte, halfword and word operands. The operations are logical shifts, arithmetic shifts, plain rotates and rotates that pass through the carry flag, in both directions, plus a bitwise complement. A datapath uses it in the execute stage. The caller supplies the operand, a width code, an operation code and the current carry. The unit returns the new value together with fresh negative, zero, overflow and carry flags.

Only the low bits selected by the width code take part. Bits above that width are ignored on the way in and come out as zero. The "top bit" is bit 7, bit 15 or bit 31, according to the width code.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (logical left) gives result = operand shifted left by one within the selected width, with bit 0 = 0. The carry becomes the old top bit.
- R2: Operation code 1 (logical right) gives result = operand shifted right by one, with the top bit = 0. The carry becomes the old bit 0.
- R3: Operation code 2 (arithmetic left) produces the same result and carry as code 0.
- R4: Operation code 3 (arithmetic right) shifts right by one and keeps the old top bit in the top position. The carry becomes the old bit 0.
- R5: Operation code 4 (rotate left) shifts left by one and places the old top bit in bit 0. The carry becomes the old top bit.
- R6: Operation code 5 (rotate right) shifts right by one and places the old bit 0 in the top position. The carry becomes the old bit 0.
- R7: Operation code 6 (rotate left through carry) shifts left by one and places the incoming carry in bit 0. The carry becomes the old top bit.
- R8: Operation code 7 (rotate right through carry) shifts right by one and places the incoming carry in the top position. The carry becomes the old bit 0.
- R9: Operation codes 8 to 15 all complement every bit within the width. The carry output equals the incoming carry.
- R10: For every operation, the overflow flag is 0, the negative flag equals the result's top bit, and the zero flag is 1 exactly when the result is zero.
- R11: Width code 0 selects 8 bits (top bit 7), code 1 selects 16 bits (top bit 15), and codes 2 and 3 select 32 bits (top bit 31). Operand bits above the width have no effect, and result bits above the width are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand; only the low bits chosen by the width code are used |
| width_sel_i | input | 2 | Width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| op_i | input | 4 | Operation code (see R1 to R9) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted, rotated or complemented value, zero above the width |
| neg_o | output | 1 | Negative flag: top bit of the result |
| zero_o | output | 1 | Zero flag: result equals zero |
| ovf_o | output | 1 | Overflow flag, always 0 |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
Whenever the inputs settle, the embedded assertions check several properties. The negative and zero flags must agree with the result. Result bits above the width must be clear. The complement must leave the carry alone. Plain rotates must keep the population count, and rotates through carry must keep the count of result plus carry. Only the bench's sweeps can show that each bit lands in the right position and that the correct bit is chosen as the carry. The sweeps cover every byte value under every code and both carries, and a set of edge and pseudo-random values at 16 and 32 bits. Upper-bit garbage in the operand is included so that R11 is observed at the outputs.

// File: rtl/shrot_unit.sv
module shrot_unit (
  input  logic [31:0] opnd_i,
  input  logic [1:0]  width_sel_i,
  input  logic [3:0]  op_i,
  input  logic        carry_i,
  output logic [31:0] result_o,
  output logic        neg_o,
  output logic        zero_o,
  output logic        ovf_o,
  output logic        carry_o
);
  localparam logic [3:0] OP_LSL = 4'd0;
  localparam logic [3:0] OP_LSR = 4'd1;
  localparam logic [3:0] OP_ASL = 4'd2;
  localparam logic [3:0] OP_ASR = 4'd3;
  localparam logic [3:0] OP_ROL = 4'd4;
  localparam logic [3:0] OP_ROR = 4'd5;
  localparam logic [3:0] OP_RCL = 4'd6;
  localparam logic [3:0] OP_RCR = 4'd7;

  logic [31:0] msk, hi, x, up, dn;
  logic        old_top, old_lsb;

  assign msk = (width_sel_i == 2'd0) ? 32'h0000_00FF :
               (width_sel_i == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign hi  = (width_sel_i == 2'd0) ? 32'h0000_0080 :
               (width_sel_i == 2'd1) ? 32'h0000_8000 : 32'h8000_0000;
  assign x       = opnd_i & msk;
  assign old_top = |(x & hi);
  assign old_lsb = x[0];
  assign up      = (x << 1) & msk;
  assign dn      = x >> 1;

  always_comb begin
    result_o = ~x & msk;
    carry_o  = carry_i;
    if (!op_i[3]) begin
      unique case (op_i)
        OP_LSL, OP_ASL: begin result_o = up;                          carry_o = old_top; end
        OP_LSR:         begin result_o = dn;                          carry_o = old_lsb; end
        OP_ASR:         begin result_o = dn | (old_top ? hi : '0);    carry_o = old_lsb; end
        OP_ROL:         begin result_o = up | {31'd0, old_top};       carry_o = old_top; end
        OP_ROR:         begin result_o = dn | (old_lsb ? hi : '0);    carry_o = old_lsb; end
        OP_RCL:         begin result_o = up | {31'd0, carry_i};       carry_o = old_top; end
        OP_RCR:         begin result_o = dn | (carry_i ? hi : '0);    carry_o = old_lsb; end
        default:        begin result_o = ~x & msk;                    carry_o = carry_i; end
      endcase
    end
  end

  assign neg_o  = |(result_o & hi);
  assign zero_o = (result_o == 32'd0);
  assign ovf_o  = 1'b0;

  always_comb begin
    AST_NEG_IS_TOP: assert (neg_o == ((result_o & hi) != 32'd0)); // R10
    AST_ZERO_FLAG: assert (zero_o == (result_o == 32'd0)); // R10
    AST_UPPER_CLEAR: assert ((result_o & ~msk) == 32'd0); // R11
    if (op_i[3]) begin
      AST_NOT_HOLDS_C: assert (carry_o == carry_i); // R9
    end
    if (op_i == OP_ROL || op_i == OP_ROR) begin
      AST_ROT_POPCOUNT: assert ($countones(result_o) == $countones(x)); // R5
    end
    if (op_i == OP_RCL || op_i == OP_RCR) begin
      AST_RC_POPCOUNT: assert (($countones(result_o) + 32'(carry_o)) ==
                               ($countones(x) + 32'(carry_i))); // R7
    end
  end
endmodule

// File: tb/test_shrot_unit.sv
module test_shrot_unit;
  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [1:0]  wsel;
  logic [3:0]  op;
  logic        cin;
  logic [31:0] res;
  logic        n, z, v, cout;
  int          nvec = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shrot_unit i_shrot_unit (
    .opnd_i(opnd), .width_sel_i(wsel), .op_i(op), .carry_i(cin),
    .result_o(res), .neg_o(n), .zero_o(z), .ovf_o(v), .carry_o(cout)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [1:0] w,
                       input logic [3:0] o, input logic c);
    longint unsigned md, half, xv, top, b0, er;
    logic ec;
    int nb;
    nb   = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    md   = 64'd1 << nb;
    half = md / 2;
    xv   = longint'(a) % md;
    top  = (xv >= half) ? 1 : 0;
    b0   = xv % 2;
    ec   = c;
    case (o)
      4'd0, 4'd2: begin er = (xv * 2) % md;                 ec = top[0]; end
      4'd1:       begin er = xv / 2;                        ec = b0[0];  end
      4'd3:       begin er = xv / 2 + top * half;           ec = b0[0];  end
      4'd4:       begin er = (xv * 2) % md + top;           ec = top[0]; end
      4'd5:       begin er = xv / 2 + b0 * half;            ec = b0[0];  end
      4'd6:       begin er = (xv * 2) % md + longint'(c);   ec = top[0]; end
      4'd7:       begin er = xv / 2 + longint'(c) * half;   ec = b0[0];  end
      default:    begin er = md - 1 - xv;                   ec = c;      end
    endcase
    @(posedge clk);
    opnd = a; wsel = w; op = o; cin = c;
    @(negedge clk);
    nvec++;
    if (longint'(res) != er || cout != ec) begin
      nfail++;
      $display("FAIL %s/R11 op=%0d w=%0d a=%h c=%0b: res=%h C=%0b expected res=%h C=%0b",
               tag_of(o), o, w, a, c, res, cout, er[31:0], ec);
    end
    if (v != 1'b0 || n != (er >= half) || z != (er == 0)) begin
      nfail++;
      $display("FAIL R10 op=%0d w=%0d a=%h: NZV=%0b%0b%0b expected NZV=%0b%0b0",
               o, w, a, n, z, v, (er >= half), (er == 0));
    end
  endtask

  initial begin
    logic [31:0] lf;
    opnd = '0; wsel = '0; op = '0; cin = 1'b0;
    // R11: byte width swept exhaustively with junk above bit 7
    for (int a = 0; a < 256; a++)
      for (int o = 0; o < 10; o++)
        for (int c = 0; c < 2; c++)
          apply({24'hC35A96, a[7:0]}, 2'd0, (o == 9) ? 4'd15 : o[3:0], c[0]);
    // R11: wider widths with edge values and a pseudo-random stream
    lf = 32'h1ACE_B00C;
    for (int w = 1; w < 4; w++)
      for (int k = 0; k < 300; k++) begin
        logic [31:0] a;
        case (k)
          0: a = 32'h0;
          1: a = 32'hFFFF_FFFF;
          2: a = 32'h8000_8001;
          3: a = 32'h0000_7FFE;
          4: a = 32'h7FFF_8000;
          default: begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a = lf;
          end
        endcase
        for (int o = 0; o < 10; o++)
          for (int c = 0; c < 2; c++)
            apply(a, w[1:0], (o == 9) ? 4'd12 : o[3:0], c[0]);
      end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule